// File: doc/BRIEF.md
# Longest Prefix Match Tree Lookup

This block resolves a routing key of variable length to a forwarding result by walking a binary decision tree held in a local node store. Host logic fills the store one node per cycle through a write port. A lookup request carries up to 248 key bits, left-aligned, together with the number of those bits that are meaningful. Starting from node 0, the engine visits one node per clock. An internal node steers the walk to one of its two children by testing a single key bit. A leaf compares a prefix of the key against its stored pattern. A leaf may name a follow-on node so the walk can go further.

Across the whole walk the engine remembers the longest leaf that matched. When the walk stops, it presents that leaf's next-hop identifier and prefix length on a valid/ready response. If no leaf matched, it reports a miss. Only one lookup is in flight at a time. The write port is honoured only while the engine is idle, so the tree cannot change under a running walk.

A node is 294 bits wide. Its fields, from bit 293 down, are:

| Bits | Field |
|------|-------|
| 293 | leaf flag |
| 292 | continue flag |
| 291:284 | bit index |
| 283:278 | pointer A |
| 277:272 | pointer B |
| 271:24 | 248-bit pattern |
| 23:16 | prefix length |
| 15:0 | next-hop id |

Key bit index i means `req_key[247-i]`, so index 0 is the most significant bit.

Top module: `lpm_tree_lookup`

## Requirements
- R1: `req_ready` is 1 only when no lookup is in progress and no response is pending. A request is taken on a cycle with `req_valid` and `req_ready` both 1. `req_ready` then stays 0 until the response has been taken.
- R2: After a request is taken, the engine visits one node per cycle, starting at node 0. For an internal node (leaf flag 0) it moves to pointer B if key bit [bit index] is 1, and to pointer A if that bit is 0. The response becomes valid after exactly as many cycles as nodes visited. Request lengths above 248 count as 248.
- R3: A leaf (leaf flag 1) matches only when its prefix length is no greater than the request length and key bits 0 to prefix length-1 equal the same bits of its pattern. A prefix length of 0 matches any key.
- R4: The result is the longest matching leaf met on the walk. A later match replaces the held one only when its prefix length is strictly greater. A leaf with the continue flag set passes the walk on to pointer A.
- R5: The walk ends at an internal node whose bit index is at or beyond the request length, and at a leaf whose continue flag is 0.
- R6: If no leaf matched, the response shows `resp_hit`=0, `resp_nh`=0 and `resp_mlen`=0. On a hit, `resp_nh` is the leaf's next-hop id and `resp_mlen` its prefix length.
- R7: While `resp_valid` is 1 and `resp_ready` is 0, the response fields hold their values.
- R8: A node write takes effect at the clock edge where `wr_en` is 1 and the engine is idle, including the edge at which a request is taken. A write offered while a lookup or response is in progress has no effect.
- R9: A walk ends after at most MAX_STEPS node visits (64 by default), even if the tree loops, and returns the best match found so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Node write strobe |
| wr_addr | input | 6 | Node address to write |
| wr_data | input | 294 | Node contents, layout as above |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_key | input | 248 | Key bits, left-aligned |
| req_len | input | 8 | Number of meaningful key bits |
| resp_valid | output | 1 | Lookup result available |
| resp_ready | input | 1 | Result consumed |
| resp_hit | output | 1 | At least one leaf matched |
| resp_nh | output | 16 | Next-hop id of the best match |
| resp_mlen | output | 8 | Prefix length of the best match |

## Verification
Two events can share a cycle: a node write and the acceptance of a request. The bench offers a write that changes the next-hop id of a leaf on the request's path, on the same edge as that request. The result must carry the new id. A write offered one cycle after acceptance must leave the following lookups unchanged. A behavioural model replays the tree walk in the bench and checks the handshake signals and the result fields on every clock. Random response back-pressure and key lengths above 248 are part of that comparison.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int KEY_W = 248;
  localparam int LEN_W = 8;
  localparam int PTR_W = 6;
  localparam int NH_W  = 16;

  typedef struct packed {
    logic             leaf;
    logic             cont;
    logic [LEN_W-1:0] bitsel;
    logic [PTR_W-1:0] ptr_a;
    logic [PTR_W-1:0] ptr_b;
    logic [KEY_W-1:0] pattern;
    logic [LEN_W-1:0] plen;
    logic [NH_W-1:0]  nh;
  } node_t;

  localparam int NODE_W = $bits(node_t);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_RESP} eng_state_t;

  // Key bit at index idx, counted from the most significant bit.
  function automatic logic key_bit(input logic [KEY_W-1:0] key,
                                   input logic [LEN_W-1:0] idx);
    logic [KEY_W-1:0] sh;
    sh = key << idx;
    return sh[KEY_W-1];
  endfunction

  // Mask covering the top len bits of a key.
  function automatic logic [KEY_W-1:0] prefix_mask(input logic [LEN_W-1:0] len);
    return ~({KEY_W{1'b1}} >> len);
  endfunction

  function automatic logic leaf_hits(input logic [KEY_W-1:0] key,
                                     input logic [LEN_W-1:0] klen,
                                     input logic [KEY_W-1:0] pattern,
                                     input logic [LEN_W-1:0] plen);
    return (plen <= klen) && (((key ^ pattern) & prefix_mask(plen)) == '0);
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    return (l > LEN_W'(KEY_W)) ? LEN_W'(KEY_W) : l;
  endfunction
endpackage

// File: rtl/lpm_node_store.sv
module lpm_node_store
  import lpm_pkg::*;
#(
  parameter int NODES = 64
) (
  input  logic             clk,
  input  logic             wr_commit,
  input  logic [PTR_W-1:0] wr_addr,
  input  node_t            wr_node,
  input  logic [PTR_W-1:0] rd_addr,
  output node_t            rd_node
);
  node_t mem [NODES];

  always_ff @(posedge clk) begin
    if (wr_commit && (int'(wr_addr) < NODES)) mem[wr_addr] <= wr_node;
  end

  always_comb begin
    if (int'(rd_addr) < NODES) rd_node = mem[rd_addr];
    else                       rd_node = '0;
  end
endmodule

// File: rtl/lpm_step_eval.sv
module lpm_step_eval
  import lpm_pkg::*;
#(
  parameter int MAX_STEPS = 64,
  localparam int STEP_W = $clog2(MAX_STEPS + 1)
) (
  input  node_t             node,
  input  logic [KEY_W-1:0]  key,
  input  logic [LEN_W-1:0]  klen,
  input  logic              best_hit,
  input  logic [LEN_W-1:0]  best_len,
  input  logic [STEP_W-1:0] steps,
  output logic [PTR_W-1:0]  nxt_ptr,
  output logic              walk_end,
  output logic              take_leaf
);
  logic leaf_ok;
  logic last_step;

  assign leaf_ok   = node.leaf && leaf_hits(key, klen, node.pattern, node.plen);
  assign take_leaf = leaf_ok && (!best_hit || (node.plen > best_len));
  assign last_step = (steps == STEP_W'(MAX_STEPS - 1));

  always_comb begin
    if (node.leaf) begin
      nxt_ptr  = node.ptr_a;
      walk_end = !node.cont || last_step;
    end else begin
      nxt_ptr  = key_bit(key, node.bitsel) ? node.ptr_b : node.ptr_a;
      walk_end = (node.bitsel >= klen) || last_step;
    end
  end
endmodule

// File: rtl/lpm_best_reg.sv
module lpm_best_reg
  import lpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [NH_W-1:0]  nh_in,
  input  logic [LEN_W-1:0] len_in,
  output logic             best_hit,
  output logic [NH_W-1:0]  best_nh,
  output logic [LEN_W-1:0] best_len
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_hit <= 1'b0;
      best_nh  <= '0;
      best_len <= '0;
    end else if (clear) begin
      best_hit <= 1'b0;
      best_nh  <= '0;
      best_len <= '0;
    end else if (load) begin
      best_hit <= 1'b1;
      best_nh  <= nh_in;
      best_len <= len_in;
    end
  end
endmodule

// File: rtl/lpm_tree_lookup.sv
module lpm_tree_lookup
  import lpm_pkg::*;
#(
  parameter int NODES     = 64,
  parameter int MAX_STEPS = 64,
  localparam int STEP_W = $clog2(MAX_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_addr,
  input  logic [NODE_W-1:0] wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KEY_W-1:0]  req_key,
  input  logic [LEN_W-1:0]  req_len,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic              resp_hit,
  output logic [NH_W-1:0]   resp_nh,
  output logic [LEN_W-1:0]  resp_mlen
);
  eng_state_t        st;
  logic [KEY_W-1:0]  key_q;
  logic [LEN_W-1:0]  len_q;
  logic [PTR_W-1:0]  cur_ptr;
  logic [STEP_W-1:0] steps;

  node_t             cur_node;
  logic [PTR_W-1:0]  nxt_ptr;
  logic              walk_end;
  logic              take_leaf;
  logic              best_hit;
  logic [NH_W-1:0]   best_nh;
  logic [LEN_W-1:0]  best_len;

  // Named events for the checker.
  logic accept;
  logic wr_commit;
  logic walking;

  assign accept    = req_valid && req_ready;
  assign wr_commit = wr_en && (st == ST_IDLE);
  assign walking   = (st == ST_WALK);

  lpm_node_store #(.NODES(NODES)) u_store (
    .clk       (clk),
    .wr_commit (wr_commit),
    .wr_addr   (wr_addr),
    .wr_node   (node_t'(wr_data)),
    .rd_addr   (cur_ptr),
    .rd_node   (cur_node)
  );

  lpm_step_eval #(.MAX_STEPS(MAX_STEPS)) u_step (
    .node      (cur_node),
    .key       (key_q),
    .klen      (len_q),
    .best_hit  (best_hit),
    .best_len  (best_len),
    .steps     (steps),
    .nxt_ptr   (nxt_ptr),
    .walk_end  (walk_end),
    .take_leaf (take_leaf)
  );

  lpm_best_reg u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .load     (walking && take_leaf),
    .nh_in    (cur_node.nh),
    .len_in   (cur_node.plen),
    .best_hit (best_hit),
    .best_nh  (best_nh),
    .best_len (best_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      key_q   <= '0;
      len_q   <= '0;
      cur_ptr <= '0;
      steps   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            key_q   <= req_key;
            len_q   <= clamp_len(req_len);
            cur_ptr <= '0;
            steps   <= '0;
            st      <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_end) begin
            st <= ST_RESP;
          end else begin
            cur_ptr <= nxt_ptr;
            steps   <= steps + 1'b1;
          end
        end
        ST_RESP: begin
          if (resp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign resp_valid = (st == ST_RESP);
  assign resp_hit   = best_hit;
  assign resp_nh    = best_nh;
  assign resp_mlen  = best_len;
endmodule

// File: rtl/lpm_tree_lookup_chk.sv
module lpm_tree_lookup_chk
  import lpm_pkg::*;
#(
  parameter int MAX_STEPS = 64,
  localparam int STEP_W = $clog2(MAX_STEPS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_hit,
  input logic [NH_W-1:0]   resp_nh,
  input logic [LEN_W-1:0]  resp_mlen,
  input logic [LEN_W-1:0]  len_q,
  input logic [STEP_W-1:0] steps
);
  // R1
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  ready_resp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && resp_valid));

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_hit)
      && $stable(resp_nh) && $stable(resp_mlen)));

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_nh == '0 && resp_mlen == '0));

  // R3
  mlen_within_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> (resp_mlen <= len_q));

  // R9
  step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(steps) < MAX_STEPS);
endmodule

bind lpm_tree_lookup lpm_tree_lookup_chk #(.MAX_STEPS(MAX_STEPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_hit   (resp_hit),
  .resp_nh    (resp_nh),
  .resp_mlen  (resp_mlen),
  .len_q      (len_q),
  .steps      (steps)
);

// File: tb/lpm_tree_lookup_bench.sv
module lpm_tree_lookup_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [293:0] wr_data = '0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [247:0] req_key = '0;
  logic [7:0]   req_len = '0;
  logic         resp_valid;
  logic         resp_ready = 1'b0;
  logic         resp_hit;
  logic [15:0]  resp_nh;
  logic [7:0]   resp_mlen;

  always #5 clk = ~clk;

  lpm_tree_lookup u_lpm_tree_lookup (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_key(req_key), .req_len(req_len),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_hit(resp_hit),
    .resp_nh(resp_nh), .resp_mlen(resp_mlen)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  int lat;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [293:0] mk_node(input bit leaf, input bit cont,
      input int bitsel, input int pa, input int pb, input logic [31:0] pat_top,
      input int plen, input int nh);
    logic [293:0] n;
    n = '0;
    n[293] = leaf;
    n[292] = cont;
    n[291:284] = bitsel[7:0];
    n[283:278] = pa[5:0];
    n[277:272] = pb[5:0];
    n[271:240] = pat_top;
    n[23:16] = plen[7:0];
    n[15:0] = nh[15:0];
    return n;
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [293:0] bmem [64];
  int m_st = 0;
  int m_cnt = 0;
  bit m_hit = 0;
  int m_nh = 0;
  int m_len = 0;

  function automatic bit bit_at(input logic [247:0] k, input int i);
    logic [247:0] s;
    s = k << i;
    return s[247];
  endfunction

  task automatic ref_walk(input logic [247:0] key, input int klen);
    int cur;
    int best;
    bit done;
    logic [293:0] n;
    cur = 0; best = -1; m_hit = 0; m_nh = 0; m_len = 0; done = 0; m_cnt = 64;
    for (int v = 1; v <= 64 && !done; v++) begin
      n = bmem[cur];
      if (n[293]) begin
        bit ok;
        ok = (int'(n[23:16]) <= klen);
        for (int i = 0; i < int'(n[23:16]); i++)
          if (bit_at(key, i) != bit_at(n[271:24], i)) ok = 0;
        if (ok && int'(n[23:16]) > best) begin
          best = int'(n[23:16]); m_hit = 1; m_nh = int'(n[15:0]); m_len = best;
        end
        if (!n[292]) begin done = 1; m_cnt = v; end
        else cur = int'(n[283:278]);
      end else begin
        if (int'(n[291:284]) >= klen) begin done = 1; m_cnt = v; end
        else cur = bit_at(key, int'(n[291:284])) ? int'(n[277:272]) : int'(n[283:278]);
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0;
    end else begin
      case (m_st)
        0: begin
          if (wr_en) bmem[wr_addr] = wr_data;
          if (req_valid) begin
            ref_walk(req_key, (int'(req_len) > 248) ? 248 : int'(req_len));
            m_st = 1;
          end
        end
        1: begin
          m_cnt--;
          if (m_cnt == 0) m_st = 2;
        end
        default: if (resp_ready) m_st = 0;
      endcase
    end
  end

  // Per-clock comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(req_ready === (m_st == 0), "R1", "req_ready", req_ready, m_st == 0);
      check(resp_valid === (m_st == 2), "R2", "resp_valid", resp_valid, m_st == 2);
      if (m_st == 2) begin
        check(resp_hit === m_hit, "R4", "resp_hit", resp_hit, m_hit);
        check(resp_nh === 16'(m_nh), "R4", "resp_nh", resp_nh, m_nh);
        check(resp_mlen === 8'(m_len), "R4", "resp_mlen", resp_mlen, m_len);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic write_node(input int a, input logic [293:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a[5:0]; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic start_req(input logic [247:0] key, input int len, input bit with_wr,
                           input int wa, input logic [293:0] wd);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_key = key; req_len = len[7:0];
    if (with_wr) begin wr_en = 1; wr_addr = wa[5:0]; wr_data = wd; end
    @(negedge clk);
    req_valid = 0; wr_en = 0;
    lat = 0;
  endtask

  task automatic finish_req(input bit chk, input bit ehit, input int enh, input int emlen,
                            input int elat, input int hold, input string tag);
    logic [15:0] nh0;
    while (!resp_valid) begin @(negedge clk); lat++; end
    if (chk) begin
      check(resp_hit === ehit, tag, "hit", resp_hit, ehit);
      check(resp_nh === 16'(enh), tag, "next-hop", resp_nh, enh);
      check(resp_mlen === 8'(emlen), tag, "mask length", resp_mlen, emlen);
      if (elat > 0) check(lat == elat, tag, "latency", lat, elat);
    end
    nh0 = resp_nh;
    for (int h = 0; h < hold; h++) @(negedge clk);
    if (hold > 0) begin
      check(resp_valid && resp_nh === nh0, "R7", "held next-hop", resp_nh, nh0);
    end
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
  endtask

  task automatic lookup(input logic [31:0] top, input int len, input bit ehit, input int enh,
                        input int emlen, input int elat, input string tag);
    start_req({top, 216'h0}, len, 0, 0, '0);
    finish_req(1, ehit, enh, emlen, elat, 0, tag);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    check(req_ready === 1'b0 || req_ready === 1'b1, "R1", "ready known", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
    check(resp_valid === 1'b0, "R1", "no response after reset", resp_valid, 0);

    write_node(0, mk_node(0, 0, 0, 1, 4, 32'h0, 0, 0));
    write_node(1, mk_node(1, 1, 0, 2, 0, 32'h0, 0, 10));
    write_node(2, mk_node(0, 0, 1, 3, 5, 32'h0, 0, 0));
    write_node(3, mk_node(1, 0, 0, 0, 0, 32'h0000_0000, 8, 11));
    write_node(4, mk_node(0, 0, 16, 7, 8, 32'h0, 0, 0));
    write_node(5, mk_node(1, 1, 0, 6, 0, 32'h4000_0000, 4, 12));
    write_node(6, mk_node(1, 0, 0, 0, 0, 32'h4000_0000, 2, 13));
    write_node(7, mk_node(1, 0, 0, 0, 0, 32'h8000_0000, 1, 14));
    write_node(8, mk_node(1, 0, 0, 0, 0, 32'hA5A5_F000, 30, 15));

    lookup(32'h0000_0000, 248, 1, 11, 8, 4, "R2");
    lookup(32'h4000_0000, 248, 1, 12, 4, 5, "R4");
    lookup(32'h4000_0000, 1, 1, 10, 0, 3, "R5");
    lookup(32'h4000_0000, 0, 0, 0, 0, 1, "R5");
    lookup(32'hA5A5_F003, 248, 1, 15, 30, 3, "R3");
    lookup(32'hA5A5_F400, 248, 0, 0, 0, 3, "R6");
    lookup(32'hA5A5_F003, 29, 0, 0, 0, 3, "R3");
    lookup(32'h8000_0000, 255, 1, 14, 1, 3, "R2");

    // R7: response held under back-pressure
    start_req({32'hA5A5_F003, 216'h0}, 248, 0, 0, '0);
    finish_req(1, 1, 15, 30, 3, 4, "R7");

    // R8: write one cycle after acceptance is dropped
    start_req({32'h0, 216'h0}, 248, 0, 0, '0);
    wr_en = 1; wr_addr = 6'd3; wr_data = mk_node(1, 0, 0, 0, 0, 32'h0, 8, 99);
    @(negedge clk);
    wr_en = 0; lat++;
    finish_req(1, 1, 11, 8, 4, 0, "R8");
    lookup(32'h0000_0000, 248, 1, 11, 8, 4, "R8");

    // R8: write on the accepting edge is visible to that walk
    start_req({32'h8000_0000, 216'h0}, 248, 1, 7, mk_node(1, 0, 0, 0, 0, 32'h8000_0000, 1, 20));
    finish_req(1, 1, 20, 1, 3, 0, "R8");

    // R9: looping tree is cut off after the step limit
    write_node(3, mk_node(0, 0, 3, 3, 3, 32'h0, 0, 0));
    lookup(32'h0000_0000, 248, 1, 10, 0, 64, "R9");
    write_node(3, mk_node(1, 0, 0, 0, 0, 32'h0000_0000, 8, 11));

    // Random traffic judged by the reference model
    for (int r = 0; r < 60; r++) begin
      logic [31:0] tops [4];
      logic [247:0] k;
      tops[0] = 32'h0000_0000; tops[1] = 32'h4000_0000;
      tops[2] = 32'h8000_0000; tops[3] = 32'hA5A5_F000;
      k = {tops[$urandom_range(0, 3)] ^ (32'($urandom) >> $urandom_range(4, 31)), 216'h0};
      start_req(k, $urandom_range(0, 255), 0, 0, '0);
      finish_req(0, 0, 0, 0, 0, $urandom_range(0, 3), "R4");
    end

    repeat (3) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule